// File: doc/BRIEF.md
# Scratchpad-Staged EEPROM Command Controller

This block sits behind the byte layer of a single-wire memory slave. After the device has been addressed, it takes the bytes the master sends and treats the first one as a memory command. It handles four commands. One loads data into an eight-byte scratchpad at a 16-bit target address. One reads that scratchpad back together with its address and status. One commits the scratchpad to the main array. One streams the main array out. A bus reset seen by the lower layer returns the block to command decode.

No write reaches the array directly. Data first lands in the scratchpad. The master reads it back to verify it, then echoes the target address and the status byte to authorise the commit. The first four 32-byte pages are user memory, and each has a protection byte in the register area that follows them. A write-protected page turns a scratchpad load into a copy of the bytes already in the array. The array is a plain register model: every byte reads FFh after reset, and there is no programming delay.

The master requests each outgoing byte with a one-cycle `rd_req`. The block answers one cycle later with `rd_vld` and `rd_byte`.

Top module: `scratch_eeprom_ctrl`

## Requirements
- R1: After reset `rd_vld` is 0 and `rd_byte` is FFh. Each `rd_req` pulse is answered by `rd_vld` high for exactly one cycle, in the following cycle, with the new byte on `rd_byte`.
- R2: Command 0Fh is followed by the low address byte, then the high address byte, then data bytes. Data is stored at scratchpad offsets starting at address bits 2:0, rising by one per byte and wrapping from 7 to 0.
- R3: The status byte has bit 7 as the copy-accepted flag, bit 5 as the partial flag and bits 2:0 as the offset of the last byte stored; bits 6, 4 and 3 are 0. When the high address byte of a 0Fh command arrives, bit 7 clears, bit 5 sets and bits 2:0 are loaded with address bits 2:0. Bit 5 clears when a byte lands at offset 7.
- R4: Command AAh returns the low address byte, the high address byte and the status byte. It then returns the scratchpad bytes from the start offset up to the ending offset (wrapping), then FFh for every further read.
- R5: Command 55h takes three echo bytes: low address, high address and status. If all three equal the stored values, the scratchpad bytes from the start offset to the ending offset are written to the array row at the target address, bit 7 of the status byte sets, and every later read returns AAh. On any mismatch the array is unchanged and reads return FFh.
- R6: Command F0h takes a low and a high address byte. If the address is below 90h, reads return successive array bytes, then FFh once address 8Fh has been passed. If the address is 90h or above, every read returns FFh.
- R7: Page p (0 to 3, addresses 20h*p to 20h*p+1Fh) has its protection byte at address 80h+p. When that byte is 55h, each data byte of a 0Fh command aimed at that page is replaced in the scratchpad by the array byte at the same address.
- R8: A bus reset during any command returns the block to command decode. Scratchpad bytes, target address and status already stored are kept.
- R9: An unknown command byte makes every read return FFh and every further byte be ignored until the next bus reset.
- R10: After reset every array byte reads FFh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | One-cycle pulse: the byte layer saw a bus reset |
| rx_vld | input | 1 | One-cycle pulse: a byte from the master is on `rx_byte` |
| rx_byte | input | 8 | Byte received from the master |
| rd_req | input | 1 | One-cycle pulse: the master is about to read a byte |
| rd_byte | output | 8 | Byte to send to the master |
| rd_vld | output | 1 | `rd_byte` was updated for the last request |

## Verification
A wrong start offset, ending offset or wrap in the scratchpad shows at the ports on the next AAh command. The data bytes come back shifted or in the wrong number, and the status byte read as the third byte disagrees. A bad comparison or a bad commit loop shows only one step later: the AAh/FFh answer after 55h is wrong, or an F0h read of the same row returns stale or misplaced bytes. Errors in the protection path and in the end-of-array limit are caught by reading back a protected page and by reading across address 8Fh, where one extra or missing byte before the FFh run is visible at once.

// File: rtl/sec_pkg.sv
package sec_pkg;

   localparam logic [7:0] CMD_LOAD   = 8'h0F;
   localparam logic [7:0] CMD_VERIFY = 8'hAA;
   localparam logic [7:0] CMD_COMMIT = 8'h55;
   localparam logic [7:0] CMD_FETCH  = 8'hF0;
   localparam logic [7:0] FILL_BYTE  = 8'hFF;
   localparam logic [7:0] DONE_BYTE  = 8'hAA;

   localparam int STAT_ACC_BIT  = 7;
   localparam int STAT_PART_BIT = 5;

   typedef enum logic [3:0] {
      ST_CMD,
      ST_LD_A1,
      ST_LD_A2,
      ST_LD_DAT,
      ST_VFY,
      ST_CM_A1,
      ST_CM_A2,
      ST_CM_ES,
      ST_CM_RUN,
      ST_CM_OK,
      ST_CM_BAD,
      ST_FT_A1,
      ST_FT_A2,
      ST_FT_DAT,
      ST_DEAD
   } st_t;

endpackage

// File: rtl/sec_scratchpad.sv
module sec_scratchpad #(
   parameter int DEPTH = 8,
   localparam int OFF_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_i,
   input  logic [OFF_W-1:0] arm_off_i,
   input  logic             wr_i,
   input  logic [7:0]       wr_data_i,
   input  logic             acc_set_i,
   input  logic [OFF_W-1:0] rd_off_i,
   output logic [7:0]       rd_data_o,
   output logic [OFF_W-1:0] wptr_o,
   output logic [OFF_W-1:0] end_o,
   output logic             part_o,
   output logic             acc_o
);

   logic [7:0] cells [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cells[g] <= 8'h00;
            end else if (wr_i && (wptr_o == OFF_W'(g))) begin
               cells[g] <= wr_data_i;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_o <= '0;
         end_o  <= '0;
         part_o <= 1'b0;
         acc_o  <= 1'b0;
      end else begin
         if (arm_i) begin
            wptr_o <= arm_off_i;
            end_o  <= arm_off_i;
            part_o <= 1'b1;
            acc_o  <= 1'b0;
         end else if (wr_i) begin
            wptr_o <= wptr_o + 1'b1;
            end_o  <= wptr_o;
            if (wptr_o == OFF_W'(DEPTH - 1)) begin
               part_o <= 1'b0;
            end
         end
         if (acc_set_i) begin
            acc_o <= 1'b1;
         end
      end
   end

   assign rd_data_o = cells[rd_off_i];

endmodule

// File: rtl/sec_array.sv
module sec_array #(
   parameter int BYTES = 144,
   localparam int IDX_W = $clog2(BYTES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we_i,
   input  logic [IDX_W-1:0] waddr_i,
   input  logic [7:0]       wdata_i,
   input  logic [IDX_W-1:0] raddr_i,
   output logic [7:0]       rdata_o,
   input  logic [IDX_W-1:0] paddr_i,
   output logic [7:0]       pdata_o
);

   logic [7:0] mem [BYTES];

   generate
      for (genvar g = 0; g < BYTES; g++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               mem[g] <= 8'hFF;
            end else if (we_i && (waddr_i == IDX_W'(g))) begin
               mem[g] <= wdata_i;
            end
         end
      end
   endgenerate

   assign rdata_o = (32'(raddr_i) < BYTES) ? mem[raddr_i] : 8'hFF;
   assign pdata_o = (32'(paddr_i) < BYTES) ? mem[paddr_i] : 8'hFF;

endmodule

// File: rtl/scratch_eeprom_ctrl.sv
module scratch_eeprom_ctrl
   import sec_pkg::*;
#(
   parameter int          ROW_BYTES  = 8,
   parameter int          PAGE_BYTES = 32,
   parameter int          NUM_PAGES  = 4,
   parameter int          REG_BYTES  = 16,
   parameter logic [7:0]  WP_CODE    = 8'h55,
   parameter bit          PROTECT_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_rst,
   input  logic       rx_vld,
   input  logic [7:0] rx_byte,
   input  logic       rd_req,
   output logic [7:0] rd_byte,
   output logic       rd_vld
);

   localparam int OFF_W      = $clog2(ROW_BYTES);
   localparam int USER_BYTES = PAGE_BYTES * NUM_PAGES;
   localparam int MEM_BYTES  = USER_BYTES + REG_BYTES;
   localparam int IDX_W      = $clog2(MEM_BYTES);
   localparam int PG_W       = $clog2(PAGE_BYTES);
   localparam int NP_W       = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
   localparam int RC_W       = $clog2(ROW_BYTES + 4) + 1;
   localparam logic [15:0] MEM_LIMIT  = 16'(MEM_BYTES);
   localparam logic [15:0] USER_LIMIT = 16'(USER_BYTES);

   generate
      if ((1 << OFF_W) != ROW_BYTES || OFF_W > 5) begin : g_bad_row
         $error("ROW_BYTES must be a power of two no larger than 32");
      end
      if ((1 << PG_W) != PAGE_BYTES || PAGE_BYTES < ROW_BYTES) begin : g_bad_page
         $error("PAGE_BYTES must be a power of two of at least one row");
      end
      if (REG_BYTES < NUM_PAGES || MEM_BYTES > 65536) begin : g_bad_regs
         $error("register area too small or array too large");
      end
   endgenerate

   st_t               st;
   logic [15:0]       ta;
   logic [7:0]        echo_lo;
   logic [7:0]        echo_hi;
   logic [RC_W-1:0]   rcnt;
   logic [OFF_W-1:0]  cp_idx;
   logic [15:0]       rm_addr;
   logic              rm_ok;
   logic [7:0]        rd_byte_q;
   logic              rd_vld_q;

   logic              sp_arm;
   logic              sp_wr;
   logic [7:0]        sp_wdata;
   logic              sp_acc_set;
   logic [OFF_W-1:0]  sp_roff;
   logic [7:0]        sp_rdata;
   logic [OFF_W-1:0]  sp_wptr;
   logic [OFF_W-1:0]  sp_end;
   logic              sp_part;
   logic              sp_acc;

   logic              mem_we;
   logic [IDX_W-1:0]  mem_waddr;
   logic [IDX_W-1:0]  mem_raddr;
   logic [7:0]        mem_rdata;
   logic [IDX_W-1:0]  mem_paddr;
   logic [7:0]        mem_pdata;

   logic [7:0]        stat_byte;
   logic [OFF_W-1:0]  start_off;
   logic [15:0]       ld_addr;
   logic [15:0]       cp_addr;
   logic              prot_hit;
   logic              rx_go;
   logic [RC_W-1:0]   vfy_k;
   logic [OFF_W-1:0]  vfy_span;
   logic              vfy_live;

   assign start_off = ta[OFF_W-1:0];
   assign ld_addr   = {ta[15:OFF_W], sp_wptr};
   assign cp_addr   = {ta[15:OFF_W], cp_idx};
   assign rx_go     = rx_vld && !bus_rst;

   always_comb begin
      stat_byte                = '0;
      stat_byte[STAT_ACC_BIT]  = sp_acc;
      stat_byte[STAT_PART_BIT] = sp_part;
      stat_byte[OFF_W-1:0]     = sp_end;
   end

   // read-back window of the scratchpad
   assign vfy_k    = rcnt - RC_W'(3);
   assign vfy_span = sp_end - start_off;
   assign vfy_live = (rcnt >= RC_W'(3)) && (vfy_k <= RC_W'(vfy_span));

   // protection lookup
   generate
      if (PROTECT_EN) begin : g_prot
         logic [NP_W-1:0] page;
         assign page      = ta[PG_W +: NP_W];
         assign mem_paddr = IDX_W'(USER_BYTES) + IDX_W'(page);
         assign prot_hit  = (ta < USER_LIMIT) && (mem_pdata == WP_CODE);
      end else begin : g_noprot
         assign mem_paddr = '0;
         assign prot_hit  = 1'b0;
      end
   endgenerate

   assign sp_arm     = rx_go && (st == ST_LD_A2);
   assign sp_wr      = rx_go && (st == ST_LD_DAT);
   assign sp_wdata   = prot_hit ? mem_rdata : rx_byte;
   assign sp_acc_set = (st == ST_CM_RUN) && (cp_idx == sp_end);
   assign sp_roff    = (st == ST_CM_RUN) ? cp_idx : (start_off + vfy_k[OFF_W-1:0]);

   assign mem_we    = (st == ST_CM_RUN) && (cp_addr < MEM_LIMIT);
   assign mem_waddr = cp_addr[IDX_W-1:0];
   assign mem_raddr = (st == ST_FT_DAT) ? rm_addr[IDX_W-1:0] : ld_addr[IDX_W-1:0];

   sec_scratchpad #(
      .DEPTH (ROW_BYTES)
   ) u_sp (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_i     (sp_arm),
      .arm_off_i (ta[OFF_W-1:0]),
      .wr_i      (sp_wr),
      .wr_data_i (sp_wdata),
      .acc_set_i (sp_acc_set),
      .rd_off_i  (sp_roff),
      .rd_data_o (sp_rdata),
      .wptr_o    (sp_wptr),
      .end_o     (sp_end),
      .part_o    (sp_part),
      .acc_o     (sp_acc)
   );

   sec_array #(
      .BYTES (MEM_BYTES)
   ) u_arr (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (mem_we),
      .waddr_i (mem_waddr),
      .wdata_i (sp_rdata),
      .raddr_i (mem_raddr),
      .rdata_o (mem_rdata),
      .paddr_i (mem_paddr),
      .pdata_o (mem_pdata)
   );

   // command sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_CMD;
         ta      <= '0;
         echo_lo <= '0;
         echo_hi <= '0;
         cp_idx  <= '0;
      end else if (st == ST_CM_RUN) begin
         if (cp_idx == sp_end) begin
            st <= ST_CM_OK;
         end else begin
            cp_idx <= cp_idx + 1'b1;
         end
      end else if (bus_rst) begin
         st <= ST_CMD;
      end else if (rx_vld) begin
         unique case (st)
            ST_CMD: begin
               unique case (rx_byte)
                  CMD_LOAD:   st <= ST_LD_A1;
                  CMD_VERIFY: st <= ST_VFY;
                  CMD_COMMIT: st <= ST_CM_A1;
                  CMD_FETCH:  st <= ST_FT_A1;
                  default:    st <= ST_DEAD;
               endcase
            end
            ST_LD_A1: begin
               ta[7:0] <= rx_byte;
               st      <= ST_LD_A2;
            end
            ST_LD_A2: begin
               ta[15:8] <= rx_byte;
               st       <= ST_LD_DAT;
            end
            ST_CM_A1: begin
               echo_lo <= rx_byte;
               st      <= ST_CM_A2;
            end
            ST_CM_A2: begin
               echo_hi <= rx_byte;
               st      <= ST_CM_ES;
            end
            ST_CM_ES: begin
               if ({echo_hi, echo_lo} == ta && rx_byte == stat_byte) begin
                  st     <= ST_CM_RUN;
                  cp_idx <= start_off;
               end else begin
                  st <= ST_CM_BAD;
               end
            end
            ST_FT_A1: st <= ST_FT_A2;
            ST_FT_A2: st <= ST_FT_DAT;
            default:  st <= st;
         endcase
      end
   end

   // outgoing bytes and read pointers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_byte_q <= FILL_BYTE;
         rd_vld_q  <= 1'b0;
         rcnt      <= '0;
         rm_addr   <= '0;
         rm_ok     <= 1'b0;
      end else begin
         rd_vld_q <= rd_req;
         if (rx_go && st == ST_CMD) begin
            rcnt <= '0;
         end
         if (rx_go && st == ST_FT_A1) begin
            rm_addr[7:0] <= rx_byte;
         end
         if (rx_go && st == ST_FT_A2) begin
            rm_addr[15:8] <= rx_byte;
            rm_ok         <= ({rx_byte, rm_addr[7:0]} < MEM_LIMIT);
         end
         if (rd_req) begin
            unique case (st)
               ST_VFY: begin
                  if (rcnt == RC_W'(0)) begin
                     rd_byte_q <= ta[7:0];
                  end else if (rcnt == RC_W'(1)) begin
                     rd_byte_q <= ta[15:8];
                  end else if (rcnt == RC_W'(2)) begin
                     rd_byte_q <= stat_byte;
                  end else if (vfy_live) begin
                     rd_byte_q <= sp_rdata;
                  end else begin
                     rd_byte_q <= FILL_BYTE;
                  end
                  if (rcnt != '1) begin
                     rcnt <= rcnt + 1'b1;
                  end
               end
               ST_CM_OK: rd_byte_q <= DONE_BYTE;
               ST_FT_DAT: begin
                  if (rm_ok) begin
                     rd_byte_q <= mem_rdata;
                     rm_addr   <= rm_addr + 1'b1;
                     if (rm_addr == MEM_LIMIT - 16'd1) begin
                        rm_ok <= 1'b0;
                     end
                  end else begin
                     rd_byte_q <= FILL_BYTE;
                  end
               end
               default: rd_byte_q <= FILL_BYTE;
            endcase
         end
      end
   end

   assign rd_byte = rd_byte_q;
   assign rd_vld  = rd_vld_q;

endmodule

// File: rtl/sec_chk.sv
module sec_chk
   import sec_pkg::*;
#(
   parameter int MEM_BYTES = 144,
   parameter int OFF_W     = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             rd_req,
   input logic             rd_vld,
   input logic [7:0]       rd_byte,
   input st_t              st,
   input logic             part,
   input logic             acc,
   input logic             sp_wr,
   input logic             sp_arm,
   input logic [OFF_W-1:0] wptr,
   input logic [15:0]      rm_addr,
   input logic             rm_ok
);

   AST_RD_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_vld);                                              // R1
   AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_vld);                                            // R1
   AST_PART_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_wr && wptr == '1) |=> !part);                                // R3
   AST_ARM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      sp_arm |=> (part && !acc));                                      // R3
   AST_COPY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_CM_OK) |-> acc);                                       // R5
   AST_FETCH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      rm_ok |-> (rm_addr < 16'(MEM_BYTES)));                           // R6
   AST_FETCH_END: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_FT_DAT && rd_req && !rm_ok) |=> (rd_byte == 8'hFF));   // R6
   AST_DEAD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DEAD && rd_req) |=> (rd_byte == 8'hFF));               // R9

endmodule

bind scratch_eeprom_ctrl sec_chk #(
   .MEM_BYTES (MEM_BYTES),
   .OFF_W     (OFF_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .rd_req  (rd_req),
   .rd_vld  (rd_vld),
   .rd_byte (rd_byte),
   .st      (st),
   .part    (sp_part),
   .acc     (sp_acc),
   .sp_wr   (sp_wr),
   .sp_arm  (sp_arm),
   .wptr    (sp_wptr),
   .rm_addr (rm_addr),
   .rm_ok   (rm_ok)
);

// File: tb/scratch_eeprom_ctrl_tb.sv
`timescale 1ns/1ps
module scratch_eeprom_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_rst = 1'b0;
   logic       rx_vld = 1'b0;
   logic [7:0] rx_byte = 8'h00;
   logic       rd_req = 1'b0;
   logic [7:0] rd_byte;
   logic       rd_vld;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   scratch_eeprom_ctrl u_dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .bus_rst (bus_rst),
      .rx_vld  (rx_vld),
      .rx_byte (rx_byte),
      .rd_req  (rd_req),
      .rd_byte (rd_byte),
      .rd_vld  (rd_vld)
   );

   // op: 0 bus reset, 1 send byte, 2 read and compare, 3 wait
   localparam int NV = 59;
   localparam logic [9:0] VEC [NV] = '{
      {2'd0,8'h00}, {2'd1,8'h0F}, {2'd1,8'h08}, {2'd1,8'h00}, {2'd1,8'h11},
      {2'd1,8'h22}, {2'd1,8'h33}, {2'd0,8'h00}, {2'd1,8'hAA}, {2'd2,8'h08},
      {2'd2,8'h00}, {2'd2,8'h22}, {2'd2,8'h11}, {2'd2,8'h22}, {2'd2,8'h33},
      {2'd2,8'hFF},
      {2'd0,8'h00}, {2'd1,8'h55}, {2'd1,8'h08}, {2'd1,8'h00}, {2'd1,8'h22},
      {2'd3,8'h00}, {2'd2,8'hAA}, {2'd2,8'hAA}, {2'd0,8'h00}, {2'd1,8'hF0},
      {2'd1,8'h08}, {2'd1,8'h00}, {2'd2,8'h11}, {2'd2,8'h22}, {2'd2,8'h33},
      {2'd2,8'hFF}, {2'd0,8'h00}, {2'd1,8'hAA}, {2'd2,8'h08}, {2'd2,8'h00},
      {2'd2,8'hA2},
      {2'd0,8'h00}, {2'd1,8'h0F}, {2'd1,8'h10}, {2'd1,8'h00}, {2'd1,8'hA1},
      {2'd0,8'h00}, {2'd1,8'h55}, {2'd1,8'h10}, {2'd1,8'h00}, {2'd1,8'h21},
      {2'd3,8'h00}, {2'd2,8'hFF}, {2'd0,8'h00}, {2'd1,8'hF0}, {2'd1,8'h10},
      {2'd1,8'h00}, {2'd2,8'hFF},
      {2'd0,8'h00}, {2'd1,8'h3C}, {2'd2,8'hFF}, {2'd1,8'h0F}, {2'd2,8'hFF}
   };

   function automatic string tag_of(int i);
      if (i < 16)      return "R4";
      else if (i < 24) return "R5";
      else if (i < 32) return "R6";
      else if (i < 37) return "R3";
      else if (i < 54) return "R5";
      else             return "R9";
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_reset();
      @(negedge clk) bus_rst = 1'b1;
      @(negedge clk) bus_rst = 1'b0;
   endtask

   task automatic send(logic [7:0] b);
      @(negedge clk) begin rx_vld = 1'b1; rx_byte = b; end
      @(negedge clk) rx_vld = 1'b0;
   endtask

   task automatic read_chk(string req, logic [7:0] exp);
      @(negedge clk) rd_req = 1'b1;
      @(negedge clk) rd_req = 1'b0;
      chk({req, " valid"}, {7'd0, rd_vld}, 8'h01);
      chk(req, rd_byte, exp);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog R1: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      // R1: reset state
      chk("R1 reset valid", {7'd0, rd_vld}, 8'h00);
      chk("R1 reset byte", rd_byte, 8'hFF);
      @(negedge clk) rst_n = 1'b1;
      idle(2);

      for (int i = 0; i < NV; i++) begin
         unique case (VEC[i][9:8])
            2'd0: bus_reset();
            2'd1: send(VEC[i][7:0]);
            2'd2: read_chk(tag_of(i), VEC[i][7:0]);
            default: idle(12);
         endcase
      end

      // R1: valid lasts one cycle
      @(negedge clk);
      chk("R1 single pulse", {7'd0, rd_vld}, 8'h00);

      // R2 R3 R4: wrap inside the row
      bus_reset(); send(8'h0F); send(8'h1E); send(8'h00);
      send(8'h61); send(8'h62); send(8'h63);
      bus_reset(); send(8'hAA);
      read_chk("R4 ta lo", 8'h1E);
      read_chk("R4 ta hi", 8'h00);
      read_chk("R3 status after wrap", 8'h00);
      read_chk("R2 off6", 8'h61);
      read_chk("R2 off7", 8'h62);
      read_chk("R2 wrap off0", 8'h63);
      read_chk("R4 fill", 8'hFF);
      bus_reset(); send(8'h55); send(8'h1E); send(8'h00); send(8'h00);
      idle(12);
      read_chk("R5 wrap commit", 8'hAA);
      bus_reset(); send(8'hF0); send(8'h18); send(8'h00);
      read_chk("R5 row 18", 8'h63);
      for (int k = 0; k < 5; k++) read_chk("R10 untouched", 8'hFF);
      read_chk("R5 row 1E", 8'h61);
      read_chk("R5 row 1F", 8'h62);

      // R7: protect page 1 after writing it
      bus_reset(); send(8'h0F); send(8'h20); send(8'h00); send(8'h5A);
      bus_reset(); send(8'h55); send(8'h20); send(8'h00); send(8'h20);
      idle(12);
      read_chk("R7 page1 commit", 8'hAA);
      bus_reset(); send(8'h0F); send(8'h81); send(8'h00); send(8'h55);
      bus_reset(); send(8'h55); send(8'h81); send(8'h00); send(8'h21);
      idle(12);
      read_chk("R7 prot commit", 8'hAA);
      bus_reset(); send(8'hAA);
      read_chk("R3 ta lo", 8'h81);
      read_chk("R3 ta hi", 8'h00);
      read_chk("R3 accepted flag", 8'hA1);
      bus_reset(); send(8'h0F); send(8'h20); send(8'h00); send(8'h77);
      bus_reset(); send(8'hAA);
      read_chk("R7 ta lo", 8'h20);
      read_chk("R7 ta hi", 8'h00);
      read_chk("R7 status", 8'h20);
      read_chk("R7 protected data", 8'h5A);
      bus_reset(); send(8'h0F); send(8'h40); send(8'h00); send(8'h77);
      bus_reset(); send(8'hAA);
      idle(1);
      read_chk("R7 ta lo page2", 8'h40);
      read_chk("R7 ta hi page2", 8'h00);
      read_chk("R7 status page2", 8'h20);
      read_chk("R7 open page data", 8'h77);

      // R8: reset in the middle of a load keeps data
      bus_reset(); send(8'h0F); send(8'h48); send(8'h00);
      send(8'h01); send(8'h02);
      bus_reset(); send(8'hAA);
      read_chk("R8 ta lo", 8'h48);
      read_chk("R8 ta hi", 8'h00);
      read_chk("R8 status", 8'h21);
      read_chk("R8 byte0", 8'h01);
      read_chk("R8 byte1", 8'h02);
      read_chk("R8 fill", 8'hFF);

      // R6: end of array
      bus_reset(); send(8'h0F); send(8'h88); send(8'h00);
      for (int k = 0; k < 8; k++) send(8'hC0 + 8'(k));
      bus_reset(); send(8'h55); send(8'h88); send(8'h00); send(8'h07);
      idle(12);
      read_chk("R6 high row commit", 8'hAA);
      bus_reset(); send(8'hF0); send(8'h8E); send(8'h00);
      read_chk("R6 8E", 8'hC6);
      read_chk("R6 8F", 8'hC7);
      read_chk("R6 past end", 8'hFF);
      read_chk("R6 past end again", 8'hFF);
      bus_reset(); send(8'hF0); send(8'h90); send(8'h00);
      read_chk("R6 start beyond", 8'hFF);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule